// File: doc/BRIEF.md
# Memory command processor for a single-wire scratchpad EEPROM slave

This block is the memory-function layer of a single-wire memory slave. The ROM layer selects the slave and then pulses `start_i`. From that point the block takes bytes that the bit-level layer has received, decodes one memory command, and answers byte requests from the master. A bus reset from the master, signalled by `bus_rst_i`, ends the transaction at any point.

The block holds four storage areas and derives a status byte from the lock state:

- a 32-byte data memory with its own 32-byte staging scratchpad;
- an 8-byte application register that can be written once;
- an 8-byte staging scratchpad for that register.

Each command that commits staged data to nonvolatile storage must be confirmed by a key byte. The committed copy then holds the block busy for a programmable number of cycles. The nonvolatile cells are modelled as registers.

Read and write addresses advance by one after every byte. They wrap inside the addressed region. Start addresses are reduced modulo the region size.

Top module: `mem_cmd_proc`

## Requirements
- R1: After `rst`, `busy_o` and `tx_valid_o` are 0. Every storage byte reads 00h, the register is unlocked, and status reads FFh.
- R2: Command 0Fh takes an address byte (taken modulo 32) and then data bytes. Each data byte is written to the data scratchpad, and the address then increments, wrapping from 31 to 0. Writing continues until a bus reset.
- R3: Command AAh takes a start address (modulo 32). Each `tx_req_i` pulse then makes `tx_valid_o` high for one cycle, one cycle later. In that cycle `tx_byte_o` carries the data scratchpad byte at the current address, and the address increments with wrap from 31 to 0. `tx_valid_o` is never high without a request in the previous cycle.
- R4: Command F0h copies the whole data memory into the data scratchpad as soon as the command byte arrives, even if a bus reset follows at once. It then reads the scratchpad as in R3.
- R5: Command 55h followed by key A5h copies all 32 scratchpad bytes into data memory. `busy_o` rises in the cycle after the key and stays high for COPY_CYCLES cycles.
- R6: Command 99h takes an address (modulo 8) and data bytes for the register scratchpad, wrapping from 7 to 0. Once the register is locked, these bytes are discarded.
- R7: Command C3h takes a start address (modulo 8) and returns 8-byte-region data as in R3. The data comes from the register scratchpad while unlocked and from the application register once locked.
- R8: Command 5Ah followed by key A5h copies the register scratchpad into the application register, sets the lock, and raises `busy_o` as in R5. A bus reset instead of the key cancels the command. Once the register is locked, the command changes nothing and does not raise `busy_o`, and the application register never changes again.
- R9: Command 66h followed by key 00h returns the status byte on every request. The status byte is FFh while unlocked and FCh once locked.
- R10: A wrong key byte for 55h, 5Ah or 66h changes no storage and raises no busy. After it, every received byte and every request is ignored until a bus reset.
- R11: While `busy_o` is high, `start_i` is ignored. Until a later accepted start, no byte is written or read.
- R12: A command byte outside 0Fh, AAh, F0h, 55h, 99h, C3h, 5Ah and 66h makes the block ignore all bytes and requests until a bus reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Pulse: slave selected, next byte is a command |
| bus_rst_i | input | 1 | Pulse: master bus reset, ends the transaction |
| rx_valid_i | input | 1 | Pulse: a received byte is present on `rx_byte_i` |
| rx_byte_i | input | 8 | Byte received from the master |
| tx_req_i | input | 1 | Pulse: master wants the next byte |
| tx_valid_o | output | 1 | One-cycle pulse: `tx_byte_o` holds the answer |
| tx_byte_o | output | 8 | Byte to send to the master |
| busy_o | output | 1 | High while a committed copy is programming |

## Verification
The embedded properties assume several things about the inputs:

- `rx_valid_i`, `tx_req_i`, `start_i` and `bus_rst_i` are single-cycle pulses and never overlap one another;
- a new transaction always opens with a bus reset followed by a start;
- the reset is applied from the first clock edge.

The stimulus drives every pulse from a task for exactly one cycle between falling edges, and it opens every command through the same reset-then-start task. Random data and random start addresses cover the full byte range, so the modulo masking and the wrap points are exercised. The copy timing is shortened by a parameter so that waits for the busy window stay short.

// File: rtl/mcp_pkg.sv
package mcp_pkg;

    localparam logic [7:0] CMD_WR_DSP  = 8'h0F;
    localparam logic [7:0] CMD_RD_DSP  = 8'hAA;
    localparam logic [7:0] CMD_LOAD_RD = 8'hF0;
    localparam logic [7:0] CMD_COMMIT  = 8'h55;
    localparam logic [7:0] CMD_WR_RSP  = 8'h99;
    localparam logic [7:0] CMD_RD_REG  = 8'hC3;
    localparam logic [7:0] CMD_LOCK    = 8'h5A;
    localparam logic [7:0] CMD_STATUS  = 8'h66;

    localparam logic [7:0] KEY_COMMIT  = 8'hA5;
    localparam logic [7:0] KEY_STATUS  = 8'h00;

    localparam logic [7:0] STAT_OPEN   = 8'hFF;
    localparam logic [7:0] STAT_SEALED = 8'hFC;

    typedef enum logic [2:0] {
        PH_IDLE, PH_CMD, PH_ADDR, PH_WRITE, PH_READ, PH_KEY, PH_STAT, PH_HALT
    } phase_e;

    typedef enum logic [2:0] {
        OP_NONE, OP_WR_DATA, OP_RD_DATA, OP_COPY_DATA,
        OP_WR_REG, OP_RD_REG, OP_LOCK_REG, OP_STATUS
    } op_e;

    // One-cycle request from the command sequencer to the storage
    typedef struct packed {
        logic       wr_dsp;
        logic       wr_rsp;
        logic       load_dsp;
        logic       commit_dm;
        logic       commit_app;
        logic [7:0] addr;
        logic [7:0] data;
    } store_req_t;

    function automatic logic [7:0] status_of(input logic sealed);
        return sealed ? STAT_SEALED : STAT_OPEN;
    endfunction

    function automatic logic [7:0] wrap_inc(input logic [7:0] a, input int unsigned size);
        return 8'((32'(a) + 32'd1) % size);
    endfunction

    function automatic logic [7:0] fold(input logic [7:0] a, input int unsigned size);
        return 8'(32'(a) % size);
    endfunction

endpackage

// File: rtl/mcp_store.sv
module mcp_store
    import mcp_pkg::*;
#(
    parameter int unsigned DATA_BYTES = 32,
    parameter int unsigned REG_BYTES  = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  store_req_t req_i,
    output logic       locked_o,
    output logic [7:0] rd_dsp_o,
    output logic [7:0] rd_reg_o
);
    localparam int unsigned DAW = (DATA_BYTES > 1) ? $clog2(DATA_BYTES) : 1;
    localparam int unsigned RAW = (REG_BYTES > 1) ? $clog2(REG_BYTES) : 1;

    logic [DATA_BYTES-1:0][7:0] dm_q, dsp_q;
    logic [REG_BYTES-1:0][7:0]  app_q, rsp_q;
    logic                       locked_q;

    logic [DAW-1:0] d_idx;
    logic [RAW-1:0] r_idx;

    assign d_idx = DAW'(32'(req_i.addr) % DATA_BYTES);
    assign r_idx = RAW'(32'(req_i.addr) % REG_BYTES);

    always_ff @(posedge clk) begin
        if (rst) begin
            dm_q     <= '0;
            dsp_q    <= '0;
            app_q    <= '0;
            rsp_q    <= '0;
            locked_q <= 1'b0;
        end else begin
            if (req_i.load_dsp)
                dsp_q <= dm_q;
            else if (req_i.wr_dsp)
                dsp_q[d_idx] <= req_i.data;
            if (req_i.commit_dm)
                dm_q <= dsp_q;
            if (req_i.wr_rsp && !locked_q)
                rsp_q[r_idx] <= req_i.data;
            if (req_i.commit_app && !locked_q) begin
                app_q    <= rsp_q;
                locked_q <= 1'b1;
            end
        end
    end

    assign locked_o = locked_q;
    assign rd_dsp_o = dsp_q[d_idx];
    assign rd_reg_o = locked_q ? app_q[r_idx] : rsp_q[r_idx];

    // R8
    lock_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        locked_q |=> locked_q);
    // R8
    app_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        locked_q |=> $stable(app_q));
    // R6
    rsp_discard_chk: assert property (@(posedge clk) disable iff (rst)
        (req_i.wr_rsp && locked_q) |=> $stable(rsp_q));
    // R10
    dm_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !req_i.commit_dm |=> $stable(dm_q));

endmodule

// File: rtl/mcp_busy_timer.sv
module mcp_busy_timer #(
    parameter int unsigned COPY_CYCLES = 500000
) (
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    output logic busy_o
);
    localparam int unsigned CW = $clog2(COPY_CYCLES + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (start_i)
            cnt_q <= CW'(COPY_CYCLES);
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign busy_o = (cnt_q != '0);

    // R5
    busy_rise_chk: assert property (@(posedge clk) disable iff (rst)
        start_i |=> busy_o);

endmodule

// File: rtl/mcp_ctrl.sv
module mcp_ctrl
    import mcp_pkg::*;
#(
    parameter int unsigned DATA_BYTES = 32,
    parameter int unsigned REG_BYTES  = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start_i,
    input  logic       bus_rst_i,
    input  logic       rx_valid_i,
    input  logic [7:0] rx_byte_i,
    input  logic       tx_req_i,
    input  logic       busy_i,
    input  logic       locked_i,
    input  logic [7:0] rd_dsp_i,
    input  logic [7:0] rd_reg_i,
    output store_req_t req_o,
    output logic       tx_valid_o,
    output logic [7:0] tx_byte_o
);
    phase_e     phase_q;
    op_e        op_q;
    logic [7:0] addr_q;

    function automatic int unsigned region_of(input op_e op);
        return (op == OP_WR_REG || op == OP_RD_REG) ? REG_BYTES : DATA_BYTES;
    endfunction

    always_comb begin
        req_o      = '0;
        req_o.addr = addr_q;
        req_o.data = rx_byte_i;
        if (rx_valid_i && !bus_rst_i) begin
            unique case (phase_q)
                PH_CMD:   req_o.load_dsp = (rx_byte_i == CMD_LOAD_RD);
                PH_WRITE: begin
                    req_o.wr_dsp = (op_q == OP_WR_DATA);
                    req_o.wr_rsp = (op_q == OP_WR_REG);
                end
                PH_KEY: begin
                    req_o.commit_dm  = (op_q == OP_COPY_DATA) && (rx_byte_i == KEY_COMMIT);
                    req_o.commit_app = (op_q == OP_LOCK_REG) && (rx_byte_i == KEY_COMMIT);
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        tx_valid_o <= 1'b0;
        if (rst) begin
            phase_q   <= PH_IDLE;
            op_q      <= OP_NONE;
            addr_q    <= '0;
            tx_byte_o <= '0;
        end else if (bus_rst_i) begin
            phase_q <= PH_IDLE;
        end else if (start_i && !busy_i) begin
            phase_q <= PH_CMD;
        end else begin
            unique case (phase_q)
                PH_CMD: if (rx_valid_i) begin
                    phase_q <= PH_ADDR;
                    unique case (rx_byte_i)
                        CMD_WR_DSP:  op_q <= OP_WR_DATA;
                        CMD_RD_DSP,
                        CMD_LOAD_RD: op_q <= OP_RD_DATA;
                        CMD_WR_RSP:  op_q <= OP_WR_REG;
                        CMD_RD_REG:  op_q <= OP_RD_REG;
                        CMD_COMMIT:  begin op_q <= OP_COPY_DATA; phase_q <= PH_KEY; end
                        CMD_LOCK:    begin op_q <= OP_LOCK_REG;  phase_q <= PH_KEY; end
                        CMD_STATUS:  begin op_q <= OP_STATUS;    phase_q <= PH_KEY; end
                        default:     begin op_q <= OP_NONE;      phase_q <= PH_HALT; end
                    endcase
                end
                PH_ADDR: if (rx_valid_i) begin
                    addr_q  <= fold(rx_byte_i, region_of(op_q));
                    phase_q <= (op_q == OP_WR_DATA || op_q == OP_WR_REG) ? PH_WRITE : PH_READ;
                end
                PH_WRITE: if (rx_valid_i)
                    addr_q <= wrap_inc(addr_q, region_of(op_q));
                PH_READ: if (tx_req_i) begin
                    tx_valid_o <= 1'b1;
                    tx_byte_o  <= (op_q == OP_RD_REG) ? rd_reg_i : rd_dsp_i;
                    addr_q     <= wrap_inc(addr_q, region_of(op_q));
                end
                PH_KEY: if (rx_valid_i)
                    phase_q <= (op_q == OP_STATUS && rx_byte_i == KEY_STATUS) ? PH_STAT : PH_HALT;
                PH_STAT: if (tx_req_i) begin
                    tx_valid_o <= 1'b1;
                    tx_byte_o  <= status_of(locked_i);
                end
                default: ;
            endcase
        end
    end

    // R11
    busy_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        busy_i |-> !(req_o.wr_dsp || req_o.wr_rsp || req_o.load_dsp || tx_valid_o));
    // R3
    tx_after_req_chk: assert property (@(posedge clk) disable iff (rst)
        tx_valid_o |-> $past(tx_req_i));

endmodule

// File: rtl/mem_cmd_proc.sv
module mem_cmd_proc
    import mcp_pkg::*;
#(
    parameter int unsigned DATA_BYTES  = 32,
    parameter int unsigned REG_BYTES   = 8,
    parameter int unsigned COPY_CYCLES = 500000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start_i,
    input  logic       bus_rst_i,
    input  logic       rx_valid_i,
    input  logic [7:0] rx_byte_i,
    input  logic       tx_req_i,
    output logic       tx_valid_o,
    output logic [7:0] tx_byte_o,
    output logic       busy_o
);
    store_req_t req;
    logic       locked;
    logic [7:0] rd_dsp, rd_reg;
    logic       copy_go;

    mcp_ctrl #(.DATA_BYTES(DATA_BYTES), .REG_BYTES(REG_BYTES)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start_i),
        .bus_rst_i  (bus_rst_i),
        .rx_valid_i (rx_valid_i),
        .rx_byte_i  (rx_byte_i),
        .tx_req_i   (tx_req_i),
        .busy_i     (busy_o),
        .locked_i   (locked),
        .rd_dsp_i   (rd_dsp),
        .rd_reg_i   (rd_reg),
        .req_o      (req),
        .tx_valid_o (tx_valid_o),
        .tx_byte_o  (tx_byte_o)
    );

    mcp_store #(.DATA_BYTES(DATA_BYTES), .REG_BYTES(REG_BYTES)) u_store (
        .clk      (clk),
        .rst      (rst),
        .req_i    (req),
        .locked_o (locked),
        .rd_dsp_o (rd_dsp),
        .rd_reg_o (rd_reg)
    );

    assign copy_go = req.commit_dm || (req.commit_app && !locked);

    mcp_busy_timer #(.COPY_CYCLES(COPY_CYCLES)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .start_i (copy_go),
        .busy_o  (busy_o)
    );

endmodule

// File: tb/mem_cmd_proc_tb.sv
module mem_cmd_proc_tb;
    localparam int CYC = 40;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start_i = 1'b0, bus_rst_i = 1'b0, rx_valid_i = 1'b0, tx_req_i = 1'b0;
    logic [7:0] rx_byte_i = 8'h00;
    logic       tx_valid_o, busy_o;
    logic [7:0] tx_byte_o;

    always #10 clk = ~clk;

    mem_cmd_proc #(.DATA_BYTES(32), .REG_BYTES(8), .COPY_CYCLES(CYC)) u_dut (
        .clk(clk), .rst(rst), .start_i(start_i), .bus_rst_i(bus_rst_i),
        .rx_valid_i(rx_valid_i), .rx_byte_i(rx_byte_i), .tx_req_i(tx_req_i),
        .tx_valid_o(tx_valid_o), .tx_byte_o(tx_byte_o), .busy_o(busy_o)
    );

    int checks = 0, fails = 0, cycles = 0;
    logic [7:0] m_dm[32], m_sp[32], m_rsp[8], m_app[8];
    bit m_lock;

    function automatic logic [7:0] exp_status(bit lk);
        return lk ? 8'hFC : 8'hFF;
    endfunction
    function automatic logic [7:0] exp_reg(int i);
        return m_lock ? m_app[i % 8] : m_rsp[i % 8];
    endfunction

    task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            checks++; fails++;
            $display("FAIL watchdog actual=%0d expected<150000", cycles);
            report();
        end
    end

    task automatic pulse_start(); @(negedge clk) start_i = 1; @(negedge clk) start_i = 0; endtask
    task automatic bus_reset(); @(negedge clk) bus_rst_i = 1; @(negedge clk) bus_rst_i = 0; endtask
    task automatic send(logic [7:0] b);
        @(negedge clk) begin rx_valid_i = 1; rx_byte_i = b; end
        @(negedge clk) rx_valid_i = 0;
    endtask
    task automatic recv(output logic [7:0] b, output bit v);
        @(negedge clk) tx_req_i = 1;
        @(negedge clk) tx_req_i = 0;
        v = tx_valid_o; b = tx_byte_o;
    endtask
    task automatic open(logic [7:0] cmd); bus_reset(); pulse_start(); send(cmd); endtask
    task automatic idle(int n); repeat (n) @(negedge clk); endtask

    task automatic read_dsp(logic [7:0] a, int n, string req);
        logic [7:0] b; bit v;
        open(8'hAA); send(a);
        for (int i = 0; i < n; i++) begin
            recv(b, v);
            chk(v && b == m_sp[(a % 32 + i) % 32], req, {v, b}, {1'b1, m_sp[(a % 32 + i) % 32]});
        end
    endtask
    task automatic read_reg(logic [7:0] a, int n, string req);
        logic [7:0] b; bit v;
        open(8'hC3); send(a);
        for (int i = 0; i < n; i++) begin
            recv(b, v);
            chk(v && b == exp_reg(a % 8 + i), req, {v, b}, {1'b1, exp_reg(a % 8 + i)});
        end
    endtask
    task automatic read_status(string req);
        logic [7:0] b; bit v;
        open(8'h66); send(8'h00);
        for (int i = 0; i < 2; i++) begin
            recv(b, v);
            chk(v && b == exp_status(m_lock), req, {v, b}, {1'b1, exp_status(m_lock)});
        end
    endtask
    task automatic expect_silent(string req);
        logic [7:0] b; bit v;
        recv(b, v);
        chk(!v, req, v, 0);
    endtask

    initial begin
        logic [7:0] a, d;
        int n;
        void'($urandom(32'h5EED));
        foreach (m_dm[i]) begin m_dm[i] = 0; m_sp[i] = 0; end
        foreach (m_rsp[i]) begin m_rsp[i] = 0; m_app[i] = 0; end
        m_lock = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        chk(!busy_o && !tx_valid_o, "R1", {busy_o, tx_valid_o}, 0);
        read_status("R1");
        read_reg(8'h00, 8, "R1");
        read_dsp(8'h00, 4, "R1");

        // R2 R3 random writes with wrap and masked addresses
        for (int k = 0; k < 4; k++) begin
            a = 8'($urandom % 256);
            n = 1 + int'($urandom % 40);
            open(8'h0F); send(a);
            for (int i = 0; i < n; i++) begin
                d = 8'($urandom);
                send(d);
                m_sp[(a % 32 + i) % 32] = d;
            end
            read_dsp(8'($urandom % 256), 34, "R2_R3");
        end
        // R2 directed wrap at 31
        open(8'h0F); send(8'h3F); send(8'hA1); send(8'hB2);
        m_sp[31] = 8'hA1; m_sp[0] = 8'hB2;
        read_dsp(8'h1F, 2, "R2");

        // R5 commit and busy
        open(8'h55); send(8'hA5);
        foreach (m_dm[i]) m_dm[i] = m_sp[i];
        chk(busy_o, "R5", busy_o, 1);
        // R11 start ignored while busy
        open(8'hAA); send(8'h00);
        expect_silent("R11");
        idle(CYC - 12);
        chk(busy_o, "R5", busy_o, 1);
        idle(14);
        chk(!busy_o, "R5", busy_o, 0);

        // R4 load via F0 with immediate reset
        open(8'h0F); send(8'h00);
        for (int i = 0; i < 32; i++) begin d = 8'($urandom); send(d); m_sp[i] = d; end
        open(8'hF0); bus_reset();
        foreach (m_sp[i]) m_sp[i] = m_dm[i];
        read_dsp(8'h00, 32, "R4");
        // R4 F0 with start address
        open(8'h0F); send(8'h05); send(8'h77); m_sp[5] = 8'h77;
        begin
            logic [7:0] b; bit v;
            open(8'hF0); send(8'h25);
            foreach (m_sp[i]) m_sp[i] = m_dm[i];
            recv(b, v);
            chk(v && b == m_dm[5], "R4", {v, b}, {1'b1, m_dm[5]});
        end

        // R10 wrong key on copy: no change
        open(8'h0F); send(8'h00);
        for (int i = 0; i < 32; i++) begin d = ~m_dm[i]; send(d); m_sp[i] = d; end
        open(8'h55); send(8'h5A);
        chk(!busy_o, "R10", busy_o, 0);
        expect_silent("R10");
        send(8'hA5);
        chk(!busy_o, "R10", busy_o, 0);
        open(8'hF0); bus_reset();
        foreach (m_sp[i]) m_sp[i] = m_dm[i];
        read_dsp(8'h00, 32, "R10");
        // R10 wrong status key
        open(8'h66); send(8'h01);
        expect_silent("R10");

        // R12 undefined command
        open(8'h12);
        expect_silent("R12");
        send(8'h00); send(8'hEE); send(8'hEE);
        read_dsp(8'h00, 3, "R12");

        // R6 R7 register scratchpad while unlocked
        a = 8'($urandom % 256);
        open(8'h99); send(a);
        for (int i = 0; i < 11; i++) begin d = 8'($urandom); send(d); m_rsp[(a % 8 + i) % 8] = d; end
        read_reg(8'($urandom % 256), 10, "R6_R7");

        // R8 cancel by bus reset
        open(8'h5A); bus_reset();
        chk(!busy_o, "R8", busy_o, 0);
        read_status("R8");
        // R8 lock
        open(8'h5A); send(8'hA5);
        foreach (m_app[i]) m_app[i] = m_rsp[i];
        m_lock = 1;
        chk(busy_o, "R8", busy_o, 1);
        idle(CYC + 5);
        read_status("R9");
        read_reg(8'h03, 9, "R7");
        // R6 writes after lock are discarded
        open(8'h99); send(8'h00);
        for (int i = 0; i < 8; i++) send(~m_app[i]);
        m_lock = 0;
        read_reg(8'h00, 8, "R6");
        m_lock = 1;
        read_reg(8'h00, 8, "R6");
        // R8 second lock has no effect
        open(8'h5A); send(8'hA5);
        chk(!busy_o, "R8", busy_o, 0);
        read_reg(8'h00, 8, "R8");
        read_status("R9");

        report();
    end
endmodule